// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block drives the read and write strobes of one parallel ATA channel for programmed-I/O and multiword DMA data cycles and for task-file register cycles. Each request arrives with a 32-bit per-device timing word, a direction bit and a select that marks it as a data cycle or a register cycle. The generator picks the counts for that kind of cycle from the word and holds them for the whole cycle. It first waits a setup period with both strobes inactive. It then pulls the selected active-low strobe down for the programmed low time. Finally it holds the strobe inactive for the programmed high time and pulses done.

Each count in the timing word is stored as the wanted number of clocks minus one. A data request that follows another data request in the same direction, and that is accepted in the done cycle of the earlier one, is treated as the next cycle of a transfer and starts its low phase at once. A data request whose word has the Ultra DMA enable bit set is refused, because this block has no burst signalling.

Top module: `ata_strobe_gen`

## Requirements
- R1: During and right after reset both strobes are high, busy, done and reject are low, and ready is high.
- R2: In a data cycle the selected strobe is low for timing_word[8:4]+1 consecutive clocks.
- R3: In a data cycle the strobe stays high for timing_word[3:0]+1 clocks after its low phase, and done is high for exactly the last of those clocks.
- R4: In a task-file cycle the low phase lasts timing_word[17:13]+1 clocks and the high phase timing_word[12:9]+1 clocks, with done on the last high clock.
- R5: Before the low phase, busy is high with both strobes high for timing_word[24:22]+1 clocks in a data cycle, or timing_word[27:25]+1 clocks in a task-file cycle. The setup starts the clock after acceptance.
- R6: req_write=1 drives diow_n and req_write=0 drives dior_n. The other strobe stays high, so both strobes are never low together.
- R7: A data request with timing_word[28]=1 is accepted, but no strobe moves and busy stays low. reject is high for one clock, the clock after acceptance. Task-file requests ignore bit 28.
- R8: Counts are taken from timing_word when a request is accepted. Changes to timing_word after that have no effect on the cycle in progress.
- R9: A data request accepted in the done clock of a data cycle with the same req_write value skips setup. Its low phase starts the clock after acceptance. Any other request gets the full setup.
- R10: req_ready is high when the block is idle or in a done clock, and low otherwise. A request is accepted on a clock edge where req_valid and req_ready are both high. Busy is high from the clock after acceptance through the done clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this clock |
| req_write | input | 1 | 1 = write (diow_n), 0 = read (dior_n) |
| req_taskfile | input | 1 | 1 = task-file register cycle, 0 = data cycle |
| timing_word | input | TW_W (32) | Per-device timing word |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| xfer_busy | output | 1 | Cycle in progress |
| xfer_done | output | 1 | One-clock pulse on the last high clock |
| req_reject | output | 1 | One-clock pulse for a refused Ultra DMA data request |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 5-bit counter, and field positions that match the requirements. With these values every setup, low and high count can be driven from 0 to its maximum of 7, 31 or 15. The sweeps therefore cover both ends of each field for both cycle kinds. Zero-gap request sequences reach the done-clock acceptance path. They cover chained data cycles, direction changes, data after task-file cycles, and refusals issued from a done clock. The timing word is scrambled whenever no request is presented, which tests that the counts are latched at acceptance.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

    // Width of the shared phase counter; must hold the widest field.
    localparam int unsigned CNT_W = 5;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2,
        PH_HIGH  = 2'd3
    } phase_e;

    // Counts for one cycle, each stored as clocks minus one.
    typedef struct packed {
        cnt_t setup;
        cnt_t low;
        cnt_t high;
    } cyc_time_t;

endpackage

// File: rtl/ata_field_sel.sv
module ata_field_sel
    import ata_strobe_pkg::*;
#(
    parameter int unsigned TW_W        = 32,
    parameter int unsigned D_HIGH_LSB  = 0,
    parameter int unsigned D_HIGH_W    = 4,
    parameter int unsigned D_LOW_LSB   = 4,
    parameter int unsigned D_LOW_W     = 5,
    parameter int unsigned T_HIGH_LSB  = 9,
    parameter int unsigned T_HIGH_W    = 4,
    parameter int unsigned T_LOW_LSB   = 13,
    parameter int unsigned T_LOW_W     = 5,
    parameter int unsigned D_SET_LSB   = 22,
    parameter int unsigned D_SET_W     = 3,
    parameter int unsigned T_SET_LSB   = 25,
    parameter int unsigned T_SET_W     = 3,
    parameter int unsigned UDMA_BIT    = 28
) (
    input  logic [TW_W-1:0] tw,
    input  logic            is_task,
    output cyc_time_t       times,
    output logic            udma_on
);

    // Index 0: data cycle fields, index 1: task-file fields.
    localparam int unsigned NKIND = 2;

    cyc_time_t kind_times [NKIND];

    for (genvar k = 0; k < NKIND; k++) begin : g_kind
        localparam int unsigned S_LSB = (k == 0) ? D_SET_LSB  : T_SET_LSB;
        localparam int unsigned S_W   = (k == 0) ? D_SET_W    : T_SET_W;
        localparam int unsigned L_LSB = (k == 0) ? D_LOW_LSB  : T_LOW_LSB;
        localparam int unsigned L_W   = (k == 0) ? D_LOW_W    : T_LOW_W;
        localparam int unsigned H_LSB = (k == 0) ? D_HIGH_LSB : T_HIGH_LSB;
        localparam int unsigned H_W   = (k == 0) ? D_HIGH_W   : T_HIGH_W;

        always_comb begin
            kind_times[k].setup = cnt_t'(tw[S_LSB +: S_W]);
            kind_times[k].low   = cnt_t'(tw[L_LSB +: L_W]);
            kind_times[k].high  = cnt_t'(tw[H_LSB +: H_W]);
        end
    end

    always_comb begin
        times   = is_task ? kind_times[1] : kind_times[0];
        udma_on = tw[UDMA_BIT];
    end

endmodule

// File: rtl/ata_phase_cnt.sv
module ata_phase_cnt #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
    import ata_strobe_pkg::*;
#(
    parameter int unsigned TW_W       = 32,
    parameter int unsigned D_HIGH_LSB = 0,
    parameter int unsigned D_HIGH_W   = 4,
    parameter int unsigned D_LOW_LSB  = 4,
    parameter int unsigned D_LOW_W    = 5,
    parameter int unsigned T_HIGH_LSB = 9,
    parameter int unsigned T_HIGH_W   = 4,
    parameter int unsigned T_LOW_LSB  = 13,
    parameter int unsigned T_LOW_W    = 5,
    parameter int unsigned D_SET_LSB  = 22,
    parameter int unsigned D_SET_W    = 3,
    parameter int unsigned T_SET_LSB  = 25,
    parameter int unsigned T_SET_W    = 3,
    parameter int unsigned UDMA_BIT   = 28
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic            req_taskfile,
    input  logic [TW_W-1:0] timing_word,
    output logic            dior_n,
    output logic            diow_n,
    output logic            xfer_busy,
    output logic            xfer_done,
    output logic            req_reject
);

    typedef struct packed {
        phase_e    phase;
        cyc_time_t hold;
        logic      wr;
        logic      tf;
        logic      rd_n;
        logic      wr_n;
        logic      rej;
    } gen_state_t;

    gen_state_t st_d, st_q;

    cyc_time_t sel_times;
    logic      sel_udma;
    logic      cnt_load;
    cnt_t      cnt_val;
    logic      cnt_zero;
    logic      accept;
    logic      chain;
    logic      last_high;

    ata_field_sel #(
        .TW_W       (TW_W),
        .D_HIGH_LSB (D_HIGH_LSB),
        .D_HIGH_W   (D_HIGH_W),
        .D_LOW_LSB  (D_LOW_LSB),
        .D_LOW_W    (D_LOW_W),
        .T_HIGH_LSB (T_HIGH_LSB),
        .T_HIGH_W   (T_HIGH_W),
        .T_LOW_LSB  (T_LOW_LSB),
        .T_LOW_W    (T_LOW_W),
        .D_SET_LSB  (D_SET_LSB),
        .D_SET_W    (D_SET_W),
        .T_SET_LSB  (T_SET_LSB),
        .T_SET_W    (T_SET_W),
        .UDMA_BIT   (UDMA_BIT)
    ) field_sel_i (
        .tw      (timing_word),
        .is_task (req_taskfile),
        .times   (sel_times),
        .udma_on (sel_udma)
    );

    ata_phase_cnt #(
        .W (CNT_W)
    ) phase_cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    assign last_high = (st_q.phase == PH_HIGH) && cnt_zero;
    assign req_ready = (st_q.phase == PH_IDLE) || last_high;
    assign accept    = req_valid && req_ready;

    always_comb begin
        st_d     = st_q;
        st_d.rej = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        chain    = 1'b0;

        // Phase progression when the running count expires.
        unique case (st_q.phase)
            PH_SETUP: begin
                if (cnt_zero) begin
                    st_d.phase = PH_LOW;
                    cnt_load   = 1'b1;
                    cnt_val    = st_q.hold.low;
                end
            end
            PH_LOW: begin
                if (cnt_zero) begin
                    st_d.phase = PH_HIGH;
                    cnt_load   = 1'b1;
                    cnt_val    = st_q.hold.high;
                end
            end
            PH_HIGH: begin
                if (cnt_zero) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: ;
        endcase

        // A new request overrides the idle transition.
        if (accept) begin
            if (!req_taskfile && sel_udma) begin
                st_d.phase = PH_IDLE;
                st_d.rej   = 1'b1;
                cnt_load   = 1'b0;
            end else begin
                chain = (st_q.phase == PH_HIGH) && !st_q.tf && !req_taskfile
                        && (st_q.wr == req_write);
                st_d.hold = sel_times;
                st_d.wr   = req_write;
                st_d.tf   = req_taskfile;
                cnt_load  = 1'b1;
                if (chain) begin
                    st_d.phase = PH_LOW;
                    cnt_val    = sel_times.low;
                end else begin
                    st_d.phase = PH_SETUP;
                    cnt_val    = sel_times.setup;
                end
            end
        end

        st_d.rd_n = !((st_d.phase == PH_LOW) && !st_d.wr);
        st_d.wr_n = !((st_d.phase == PH_LOW) &&  st_d.wr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.rd_n  <= 1'b1;
            st_q.wr_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dior_n     = st_q.rd_n;
    assign diow_n     = st_q.wr_n;
    assign xfer_busy  = (st_q.phase != PH_IDLE);
    assign xfer_done  = last_high;
    assign req_reject = st_q.rej;

endmodule

// File: rtl/ata_strobe_chk.sv
module ata_strobe_chk #(
    parameter int unsigned TW_W     = 32,
    parameter int unsigned UDMA_BIT = 28
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_taskfile,
    input logic [TW_W-1:0] timing_word,
    input logic            dior_n,
    input logic            diow_n,
    input logic            xfer_busy,
    input logic            xfer_done,
    input logic            req_reject
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (dior_n || diow_n)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R3

    AST_DONE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (dior_n && diow_n && xfer_busy)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy |-> (dior_n && diow_n && !xfer_done)); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !xfer_done) |-> !req_ready); // R10

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> (!xfer_busy && dior_n && diow_n)); // R7

    AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_taskfile && timing_word[UDMA_BIT])
        |=> (req_reject && !xfer_busy)); // R7

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_taskfile || !timing_word[UDMA_BIT]))
        |=> (xfer_busy && !req_reject)); // R10

endmodule

bind ata_strobe_gen ata_strobe_chk #(
    .TW_W     (TW_W),
    .UDMA_BIT (UDMA_BIT)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_taskfile (req_taskfile),
    .timing_word  (timing_word),
    .dior_n       (dior_n),
    .diow_n       (diow_n),
    .xfer_busy    (xfer_busy),
    .xfer_done    (xfer_done),
    .req_reject   (req_reject)
);

// File: tb/ata_strobe_gen_tb_top.sv
module ata_strobe_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic        req_taskfile;
    logic [31:0] timing_word;
    logic        dior_n, diow_n, xfer_busy, xfer_done, req_reject;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ata_strobe_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_taskfile (req_taskfile),
        .timing_word  (timing_word),
        .dior_n       (dior_n),
        .diow_n       (diow_n),
        .xfer_busy    (xfer_busy),
        .xfer_done    (xfer_done),
        .req_reject   (req_reject)
    );

    typedef struct {
        bit          w;
        bit          t;
        logic [31:0] tw;
        int          gap;
    } cmd_t;

    // Expected per clock: {reject, done, busy, dior_n, diow_n}
    localparam logic [4:0] IDLE_E = 5'b00011;

    cmd_t        cq[$];
    logic [4:0]  exp_q[$];
    string       tag_q[$];

    function automatic cmd_t mk(bit w, bit t, int s, int l, int h, bit udma, int gap);
        cmd_t c;
        logic [31:0] x;
        x = $urandom;
        if (t) begin
            x[27:25] = 3'(s); x[17:13] = 5'(l); x[12:9] = 4'(h);
        end else begin
            x[24:22] = 3'(s); x[8:4] = 5'(l); x[3:0] = 4'(h);
        end
        x[28] = udma;
        c.w = w; c.t = t; c.tw = x; c.gap = gap;
        return c;
    endfunction

    task automatic push_seq(cmd_t c, bit chain);
        int s, l, h;
        if (!c.t && c.tw[28]) begin
            exp_q.push_back(5'b10011); tag_q.push_back("R7");
            return;
        end
        s = c.t ? int'(c.tw[27:25]) : int'(c.tw[24:22]);
        l = c.t ? int'(c.tw[17:13]) : int'(c.tw[8:4]);
        h = c.t ? int'(c.tw[12:9])  : int'(c.tw[3:0]);
        if (!chain) begin
            for (int i = 0; i <= s; i++) begin
                exp_q.push_back(5'b00111); tag_q.push_back("R5");
            end
        end
        for (int i = 0; i <= l; i++) begin
            exp_q.push_back({3'b001, c.w, !c.w});
            if (chain) tag_q.push_back("R9 R6 R8");
            else       tag_q.push_back(c.t ? "R4 R6 R8" : "R2 R6 R8");
        end
        for (int i = 0; i < h; i++) begin
            exp_q.push_back(5'b00111); tag_q.push_back(c.t ? "R4" : "R3");
        end
        exp_q.push_back(5'b01111); tag_q.push_back(c.t ? "R4 done" : "R3 done");
    endtask

    task automatic check(string tag, logic [5:0] got, logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got {ready,rej,done,busy,rd_n,wr_n}=%b expected %b at %0t",
                     tag, got, exp, $time);
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] e;
        string      tag;
        bit         rdy_e;
        bit         have_prev;
        bit         prev_w, prev_t;
        bit         chain;
        int         gap;

        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_taskfile = 1'b0; timing_word = '0;
        have_prev = 0; prev_w = 0; prev_t = 0;

        // Sweeps over every field value, both cycle kinds (R2 R3 R4 R5).
        for (int v = 0; v < 32; v++) cq.push_back(mk(0, 0, v % 8, v, v % 16, 0, 1));
        for (int v = 0; v < 16; v++) cq.push_back(mk(1, 0, 7 - (v % 8), 31 - v, v, 0, 2));
        for (int v = 0; v < 32; v++) cq.push_back(mk(v % 2, 1, v % 8, v, 15 - (v % 16), v[1], 1));
        // Back-to-back chains and breaks (R9).
        cq.push_back(mk(1, 0, 5, 2, 1, 0, 0));
        cq.push_back(mk(1, 0, 5, 0, 0, 0, 0));
        cq.push_back(mk(1, 0, 5, 3, 2, 0, 0));
        cq.push_back(mk(0, 0, 4, 1, 1, 0, 0));
        cq.push_back(mk(0, 0, 4, 0, 3, 0, 0));
        cq.push_back(mk(0, 1, 2, 1, 0, 0, 0));
        cq.push_back(mk(0, 0, 3, 1, 0, 0, 0));
        cq.push_back(mk(0, 1, 1, 0, 0, 0, 0));
        cq.push_back(mk(0, 1, 1, 2, 0, 0, 0));
        // Refusals (R7), including one taken in a done clock and one chained after.
        cq.push_back(mk(1, 0, 2, 2, 2, 1, 3));
        cq.push_back(mk(1, 0, 2, 2, 2, 0, 0));
        cq.push_back(mk(1, 0, 2, 2, 2, 1, 0));
        cq.push_back(mk(1, 0, 2, 2, 2, 0, 0));
        cq.push_back(mk(1, 0, 0, 0, 0, 1, 0));
        cq.push_back(mk(1, 1, 0, 0, 0, 1, 2));

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {req_ready, req_reject, xfer_done, xfer_busy, dior_n, diow_n},
              {1'b1, IDLE_E});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {req_ready, req_reject, xfer_done, xfer_busy, dior_n, diow_n},
              {1'b1, IDLE_E});

        gap = cq[0].gap;
        while (cq.size() > 0 || exp_q.size() > 0) begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                tag = tag_q.pop_front();
            end else begin
                e = IDLE_E;
                tag = "R10 idle";
            end
            rdy_e = !e[2] || e[3];
            check(tag, {req_ready, req_reject, xfer_done, xfer_busy, dior_n, diow_n},
                  {rdy_e, e});

            if (cq.size() > 0 && gap == 0) begin
                req_valid    = 1'b1;
                req_write    = cq[0].w;
                req_taskfile = cq[0].t;
                timing_word  = cq[0].tw;
                if (rdy_e) begin
                    chain = e[3] && have_prev && !prev_t && !cq[0].t && (prev_w == cq[0].w);
                    push_seq(cq[0], chain);
                    if (cq[0].t || !cq[0].tw[28]) begin
                        have_prev = 1; prev_w = cq[0].w; prev_t = cq[0].t;
                    end
                    void'(cq.pop_front());
                    if (cq.size() > 0) gap = cq[0].gap;
                end
            end else begin
                // Nothing presented: scramble the other inputs (R8).
                req_valid    = 1'b0;
                req_write    = 1'($urandom);
                req_taskfile = 1'($urandom);
                timing_word  = $urandom;
                if (gap > 0) gap--;
            end
        end

        req_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R10 final idle", {req_ready, req_reject, xfer_done, xfer_busy, dior_n, diow_n},
                  {1'b1, IDLE_E});
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule